// File: doc/BRIEF.md
# Wait-for-event decode and control unit

This block recognises the wait-for-event hint in an instruction stream and carries out its effect. It accepts either a 32-bit fixed-length word or a word from a mixed 16/32-bit compressed stream. For the compressed stream, the first halfword always sits in the upper half of the input word. When a valid instruction decodes as the hint, the block first checks the condition code against the flags. It then looks at its one-bit event register. If the register is set, the block clears it and finishes at once. If the register is clear, the block checks the trap enables of the privilege levels in a fixed priority order. It then either reports a trap or an undefined-instruction result, or raises a low-power request.

A send-event pulse from any core sets the event register. While the low-power request is held, a send-event pulse, a pending interrupt or an event register that is already set ends the wait. The request then drops and the event register is cleared. All results are registered: they appear one clock after the instruction or the event that causes them.

Top module: `evt_wait_unit`

## Requirements
- R1: In fixed-length mode (mode=0) a word decodes as the hint when bits [31:28] are not 1111, bits [27:16] equal 0x320 and bits [7:0] equal 0x02; bits [15:8] are ignored for decode.
- R2: In compressed mode (mode=1) an upper halfword of 0xBF20 decodes as the 16-bit hint.
- R3: In compressed mode an upper halfword whose bits [15:4] are 0xF3A, together with a lower halfword that equals 0x8002 once bits 13 and 11 are ignored, decodes as the 32-bit hint; bits [3:0] of the upper halfword are ignored.
- R4: A fixed-length hint whose condition fails has no effect on any output. The flags are {N,Z,C,V} on flags[3:0], and cond 0000 (EQ) passes only when Z is 1. Compressed forms always pass.
- R5: A hint executed with the event register set clears the register and produces no trap, no undefined result and no low-power request, whatever the trap enables say.
- R6: A send-event pulse sets the event register one cycle later; if it coincides with a clear caused by a hint, the register ends up set.
- R7: With the event register clear, EL3 present, the undefined-priority input high and the EL3 trap enabled, the hint gives a one-cycle undefined_pulse ahead of every other trap check.
- R8: Otherwise traps are checked in this order: EL1 trap only at EL0 (level code 01), then EL2 trap at EL0 or EL1 with EL2 enabled and not in host mode (code 10), then EL3 trap with EL3 present and not in monitor mode (code 11).
- R9: With no trap taken, lp_req rises and stays high until send-event or a pending interrupt, then drops and leaves the event register clear.
- R10: trap_pulse lasts one cycle, carries a non-zero trap_level, and leaves the event register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dec_valid | input | 1 | Instruction word is valid this cycle |
| isa_mode | input | 1 | 0 fixed-length, 1 compressed |
| insn | input | 32 | Instruction word (compressed: first halfword in [31:16]) |
| flags | input | 4 | Condition flags {N,Z,C,V} |
| cur_el | input | 2 | Current exception level |
| monitor_mode | input | 1 | Core is in monitor mode |
| host_mode | input | 1 | Core is in host mode |
| el2_enabled | input | 1 | EL2 is enabled |
| el3_present | input | 1 | EL3 is implemented |
| el3_undef_prio | input | 1 | EL3 trap takes undefined priority |
| trap_en_el1 | input | 1 | EL1 trap enable |
| trap_en_el2 | input | 1 | EL2 trap enable |
| trap_en_el3 | input | 1 | EL3 trap enable |
| sev_in | input | 1 | Send-event pulse from any core |
| irq_pending | input | 1 | Pending interrupt |
| is_wfe | output | 1 | Combinational decode hit |
| trap_pulse | output | 1 | One-cycle trap indication |
| trap_level | output | 2 | Target level of the trap |
| undef_pulse | output | 1 | One-cycle undefined-instruction indication |
| lp_req | output | 1 | Low-power request |
| event_reg | output | 1 | Event register |

## Verification
The decoder is tried with exact encodings, with encodings whose should-be-one and should-be-zero bits are flipped, and with near misses such as cond 1111 and a different hint halfword. This tells lenient decode apart from a wrong mask. Execution is driven with the event register set and clear and with the traps enabled one at a time and together, which separates the shortcut from the ordered checks and exposes each priority. Wakeups come from send-event and from an interrupt. Send-event is also made to coincide with a clear, which tells set-over-clear priority apart.

// File: rtl/evt_wait_unit.sv
module evt_wait_unit (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        dec_valid,
  input  logic        isa_mode,
  input  logic [31:0] insn,
  input  logic [3:0]  flags,
  input  logic [1:0]  cur_el,
  input  logic        monitor_mode,
  input  logic        host_mode,
  input  logic        el2_enabled,
  input  logic        el3_present,
  input  logic        el3_undef_prio,
  input  logic        trap_en_el1,
  input  logic        trap_en_el2,
  input  logic        trap_en_el3,
  input  logic        sev_in,
  input  logic        irq_pending,
  output logic        is_wfe,
  output logic        trap_pulse,
  output logic [1:0]  trap_level,
  output logic        undef_pulse,
  output logic        lp_req,
  output logic        event_reg
);

  logic [15:0] hw_hi, hw_lo;
  logic [3:0]  cond;
  logic        fix_hit, c16_hit, c32_hit, wide_hw;
  logic        cond_ok, fire;
  logic        undef_c, t1, t2, t3, wake;
  logic        fn, fz, fc, fv;

  assign hw_hi = insn[31:16];
  assign hw_lo = insn[15:0];
  assign cond  = insn[31:28];
  assign {fn, fz, fc, fv} = flags;

  assign fix_hit = (cond != 4'hF) && (insn[27:16] == 12'h320) && (insn[7:0] == 8'h02);
  assign wide_hw = (hw_hi[15:13] == 3'b111) && (hw_hi[12:11] != 2'b00);
  assign c16_hit = !wide_hw && (hw_hi == 16'hBF20);
  assign c32_hit = wide_hw && (hw_hi[15:4] == 12'hF3A) && ((hw_lo & ~16'h2800) == 16'h8002);
  assign is_wfe  = isa_mode ? (c16_hit || c32_hit) : fix_hit;

  always_comb begin
    case (cond[3:1])
      3'd0: cond_ok = fz;
      3'd1: cond_ok = fc;
      3'd2: cond_ok = fn;
      3'd3: cond_ok = fv;
      3'd4: cond_ok = fc && !fz;
      3'd5: cond_ok = (fn == fv);
      3'd6: cond_ok = !fz && (fn == fv);
      default: cond_ok = 1'b1;
    endcase
    if (cond[0] && cond[3:1] != 3'd7) cond_ok = !cond_ok;
    if (isa_mode) cond_ok = 1'b1;
  end

  assign fire    = dec_valid && is_wfe && cond_ok && !lp_req;
  assign undef_c = el3_present && el3_undef_prio && trap_en_el3;
  assign t1      = (cur_el == 2'd0) && trap_en_el1;
  assign t2      = (cur_el <= 2'd1) && el2_enabled && !host_mode && trap_en_el2;
  assign t3      = el3_present && !monitor_mode && trap_en_el3;
  assign wake    = sev_in || irq_pending || event_reg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trap_pulse  <= 1'b0;
      trap_level  <= 2'd0;
      undef_pulse <= 1'b0;
      lp_req      <= 1'b0;
      event_reg   <= 1'b0;
    end else begin
      trap_pulse  <= 1'b0;
      trap_level  <= 2'd0;
      undef_pulse <= 1'b0;
      if (lp_req) begin
        if (wake) begin
          lp_req    <= 1'b0;
          event_reg <= 1'b0;
        end
      end else if (fire) begin
        event_reg <= sev_in;
        if (!event_reg) begin
          if (undef_c) undef_pulse <= 1'b1;
          else if (t1) begin trap_pulse <= 1'b1; trap_level <= 2'd1; end
          else if (t2) begin trap_pulse <= 1'b1; trap_level <= 2'd2; end
          else if (t3) begin trap_pulse <= 1'b1; trap_level <= 2'd3; end
          else lp_req <= 1'b1;
        end
      end else begin
        event_reg <= event_reg || sev_in;
      end
    end
  end

  // R9
  wake_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lp_req && (sev_in || irq_pending) |=> !lp_req && !event_reg);

  // R6
  sev_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lp_req && sev_in |=> event_reg);

  // R10
  trap_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap_pulse && !$past(sev_in) |-> !event_reg);

  // R8
  trap_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap_pulse |-> trap_level != 2'd0);

  // R7
  undef_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({trap_pulse, undef_pulse, lp_req && !$past(lp_req)}));

  // R5
  evt_shortcut_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire && event_reg |=> !trap_pulse && !undef_pulse && !lp_req);

endmodule

// File: tb/evt_wait_unit_bench.sv
`timescale 1ns/1ps
module evt_wait_unit_bench;
  logic clk = 0, rst_n = 0;
  logic dec_valid = 0, isa_mode = 0;
  logic [31:0] insn = 0;
  logic [3:0] flags = 0;
  logic [1:0] cur_el = 2'd1;
  logic monitor_mode = 0, host_mode = 0, el2_enabled = 0, el3_present = 0, el3_undef_prio = 0;
  logic trap_en_el1 = 0, trap_en_el2 = 0, trap_en_el3 = 0, sev_in = 0, irq_pending = 0;
  logic is_wfe, trap_pulse, undef_pulse, lp_req, event_reg;
  logic [1:0] trap_level;
  int errors = 0, checks = 0;
  bit done = 0;
  logic [5:0] expq[$];
  string tagq[$];

  localparam logic [31:0] FIX_AL = 32'hE320_F002;
  localparam logic [31:0] FIX_EQ = 32'h0320_F002;

  always #10 clk = ~clk;

  evt_wait_unit u_evt_wait_unit (.*);

  task automatic check(input string tag, input logic [5:0] act, input logic [5:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic step(input bit v, input logic [31:0] w, input bit m, input bit s,
                      input bit q, input logic [5:0] e, input string t);
    @(negedge clk);
    dec_valid = v; insn = w; isa_mode = m; sev_in = s; irq_pending = q;
    expq.push_back(e); tagq.push_back(t);
    @(negedge clk);
    dec_valid = 0; sev_in = 0; irq_pending = 0;
  endtask

  task automatic dec(input logic [31:0] w, input bit m, input bit e, input string t);
    @(negedge clk);
    dec_valid = 0; insn = w; isa_mode = m;
    #1 check(t, {5'd0, is_wfe}, {5'd0, e});
  endtask

  always @(posedge clk) begin
    #1;
    if (expq.size() > 0)
      check(tagq.pop_front(), {trap_pulse, trap_level, undef_pulse, lp_req, event_reg}, expq.pop_front());
  end

  initial begin
    #(20 * 5000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("reset", {trap_pulse, trap_level, undef_pulse, lp_req, event_reg}, 6'b0);
    rst_n = 1;
    // R1 R2 R3 decode
    dec(FIX_AL, 0, 1, "R1 fixed exact");
    dec(32'hE320_0A02, 0, 1, "R1 fixed sbo/sbz flipped");
    dec(32'hF320_F002, 0, 0, "R1 cond 1111 rejected");
    dec(32'hBF20_0000, 1, 1, "R2 16-bit hint");
    dec(32'hBF40_0000, 1, 0, "R2 other hint");
    dec(32'hF3AF_8002, 1, 1, "R3 32-bit exact");
    dec(32'hF3A0_A802, 1, 1, "R3 32-bit sbo/sbz flipped");
    dec(32'hF3AF_8004, 1, 0, "R3 wrong option");
    // R9 sleep and wake
    step(1, FIX_AL, 0, 0, 0, 6'b000010, "R9 enter low power");
    step(0, 0, 0, 0, 1, 6'b000000, "R9 irq wake");
    // R6 sev sets
    step(0, 0, 0, 1, 0, 6'b000001, "R6 sev sets");
    // R4 cond fail keeps event
    flags = 4'b0000;
    step(1, FIX_EQ, 0, 0, 0, 6'b000001, "R4 EQ fails no effect");
    // R5 shortcut despite traps
    cur_el = 0; trap_en_el1 = 1;
    step(1, FIX_AL, 0, 0, 0, 6'b000000, "R5 event clear shortcut");
    // R8 EL1 trap, R10
    step(1, FIX_AL, 0, 0, 0, 6'b101000, "R8 EL1 trap");
    trap_en_el2 = 1; el2_enabled = 1;
    step(1, FIX_AL, 0, 0, 0, 6'b101000, "R8 EL1 before EL2");
    cur_el = 1;
    step(1, FIX_AL, 0, 0, 0, 6'b110000, "R8 EL2 trap");
    host_mode = 1; el3_present = 1; trap_en_el3 = 1;
    step(1, FIX_AL, 0, 0, 0, 6'b111000, "R8 EL3 trap in host");
    step(0, 0, 0, 0, 0, 6'b000000, "R10 trap one cycle");
    monitor_mode = 1;
    step(1, FIX_AL, 0, 0, 0, 6'b000010, "R8 monitor skips EL3");
    step(0, 0, 0, 1, 0, 6'b000000, "R9 sev wake clears event");
    monitor_mode = 0;
    // R7 undef priority
    cur_el = 0; el3_undef_prio = 1;
    step(1, FIX_AL, 0, 0, 0, 6'b000100, "R7 undef first");
    // R10 trap with sev leaves event set only by sev
    el3_undef_prio = 0;
    step(1, FIX_AL, 0, 1, 0, 6'b101001, "R10 trap with coincident sev");
    // R6 set beats clear
    step(1, FIX_AL, 0, 1, 0, 6'b000001, "R6 set wins over clear");
    step(1, FIX_AL, 0, 0, 0, 6'b000000, "R5 clear again");
    // compressed forms sleep
    trap_en_el1 = 0; trap_en_el2 = 0; trap_en_el3 = 0;
    step(1, 32'hBF20_0000, 1, 0, 0, 6'b000010, "R2 16-bit executes");
    step(1, FIX_AL, 0, 0, 0, 6'b000010, "R9 held while waiting");
    step(0, 0, 0, 0, 1, 6'b000000, "R9 irq wake");
    step(1, 32'hF3A0_A802, 1, 0, 0, 6'b000010, "R3 32-bit executes");
    step(0, 0, 0, 1, 0, 6'b000000, "R9 sev wake");
    step(1, 32'hF320_F002, 0, 0, 0, 6'b000000, "R1 non-hint no effect");
    repeat (3) @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule